// File: doc/BRIEF.md
# Infrared Receive Pulse-Width Filter

This block is the receive front end of an infrared encoder/decoder that sits next to a UART. It samples a serial infrared receive line synchronously and rejects pulses that are too narrow. A one-cycle strobe goes toward the UART receive path for each pulse it accepts. A byte-wide control register sets the minimum pulse width. The same register holds a loopback switch, a receive gate and a master enable.

The minimum-width field is four bits. When it is zero, the filter works as a plain rising-edge detector and accepts pulses of any width. When it is nonzero, a 6-bit down-counter is loaded on each rising edge of the synchronized input. The field supplies the counter's upper four bits and its lower two bits are fixed at 3. The pulse is accepted only if the line is still high after field*4+3 system clocks.

In loopback, the inverted transmit output feeds the receive path in place of the external pin. This allows the UART to be tested internally.

Top module: `irda_rx_filter`

## Requirements
- R1: After reset, `cfg_rdata` reads 0x00 and `rx_pulse` is low.
- R2: The register fields are: bits [7:4] minimum width, bit 2 loopback, bit 1 receive enable, bit 0 enable. Bit 3 always reads 0, whatever value was written to it, so writing 0xFF reads back 0xF7.
- R3: The selected receive source passes through two flops before edge detection. With field 0, `rx_pulse` is high in the cycle after the third rising clock edge that samples the source high.
- R4: With field 0, every rising edge of the synchronized source gives a strobe, including a pulse only one clock wide.
- R5: With field F nonzero, a pulse that stays high for at least F*4+3 clocks gives a strobe on the (F*4+3)-th high cycle. A shorter pulse gives none.
- R6: `rx_pulse` lasts a single cycle, and one input pulse gives at most one strobe, however long it is.
- R7: The width used for a pulse is the field value held when its rising edge is detected. A write during the pulse does not change it.
- R8: With loopback set, the source is the inverse of `tx_pin`, and activity on `ir_rx_pin` has no effect.
- R9: With receive enable at 0, no strobes are issued.
- R10: With enable at 0, no strobes are issued.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_we | input | 1 | Control register write strobe |
| cfg_wdata | input | 8 | Control register write data |
| cfg_rdata | output | 8 | Control register read value |
| ir_rx_pin | input | 1 | External infrared receive line, active high |
| tx_pin | input | 1 | Transmit output, used inverted in loopback |
| rx_pulse | output | 1 | One-cycle strobe for an accepted pulse |

## Verification
On every cycle, the assertions check the following:
- the reserved bit reads zero;
- the strobe never lasts two cycles;
- a strobe follows only a cycle that was enabled and had the synchronized line high;
- the counter never sits at zero while it is armed.

The width threshold can only be shown by the bench's scenarios. These cover the boundary widths at the smallest and largest field values, the field latched at the rising edge during a mid-pulse write, loopback inversion, and gating by the two enables. A behavioural model checks all of them cycle by cycle.

// File: rtl/irda_rx_filter.sv
module irda_rx_filter #(
  parameter int FW = 4,
  parameter int CW = FW + 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       cfg_we,
  input  logic [7:0] cfg_wdata,
  output logic [7:0] cfg_rdata,
  input  logic       ir_rx_pin,
  input  logic       tx_pin,
  output logic       rx_pulse
);
  logic [FW-1:0] min_w;
  logic          lb, rx_en, en;
  logic          s1, s2, s3;
  logic          armed;
  logic [CW-1:0] cnt;

  wire active = en & rx_en;
  wire src    = lb ? ~tx_pin : ir_rx_pin;
  wire rise   = s2 & ~s3;

  assign cfg_rdata = {min_w, 1'b0, lb, rx_en, en};

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      min_w <= '0; lb <= 1'b0; rx_en <= 1'b0; en <= 1'b0;
    end else if (cfg_we) begin
      min_w <= cfg_wdata[7:4];
      lb    <= cfg_wdata[2];
      rx_en <= cfg_wdata[1];
      en    <= cfg_wdata[0];
    end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      s1 <= 1'b0; s2 <= 1'b0; s3 <= 1'b0;
      armed <= 1'b0; cnt <= '0; rx_pulse <= 1'b0;
    end else begin
      s1 <= src; s2 <= s1; s3 <= s2;
      rx_pulse <= 1'b0;
      if (!active) armed <= 1'b0;
      else if (rise) begin
        if (min_w == '0) rx_pulse <= 1'b1;
        else begin
          cnt   <= {min_w, 2'b11};
          armed <= 1'b1;
        end
      end else if (armed) begin
        if (!s2) armed <= 1'b0;
        else if (cnt == CW'(2)) begin
          rx_pulse <= 1'b1;
          armed    <= 1'b0;
        end else cnt <= cnt - 1'b1;
      end
    end
endmodule

module irda_rx_filter_chk #(parameter int CW = 6) (
  input logic          clk,
  input logic          rst_n,
  input logic [7:0]    cfg_rdata,
  input logic          rx_pulse,
  input logic          s2,
  input logic          armed,
  input logic [CW-1:0] cnt
);
  AST_RSVD_ZERO: assert property (@(posedge clk) disable iff (!rst_n) cfg_rdata[3] == 1'b0); // R2
  AST_SINGLE_STROBE: assert property (@(posedge clk) disable iff (!rst_n) rx_pulse |=> !rx_pulse); // R6
  AST_STROBE_NEEDS_HIGH: assert property (@(posedge clk) disable iff (!rst_n) rx_pulse |-> $past(s2)); // R5
  AST_STROBE_ENABLED: assert property (@(posedge clk) disable iff (!rst_n) rx_pulse |-> ($past(cfg_rdata[1:0]) == 2'b11)); // R9
  AST_ARMED_NONZERO: assert property (@(posedge clk) disable iff (!rst_n) armed |-> (cnt >= CW'(2))); // R5
endmodule

bind irda_rx_filter irda_rx_filter_chk #(.CW(CW)) u_chk (
  .clk(clk), .rst_n(rst_n), .cfg_rdata(cfg_rdata), .rx_pulse(rx_pulse),
  .s2(s2), .armed(armed), .cnt(cnt)
);

// File: tb/sim_irda_rx_filter.sv
module sim_irda_rx_filter;
  logic clk = 0, rst_n = 0, cfg_we = 0, ir_rx_pin = 0, tx_pin = 1;
  logic [7:0] cfg_wdata = 0, cfg_rdata;
  logic rx_pulse;
  int checks = 0, fails = 0, strobes = 0;

  irda_rx_filter u0 (.clk, .rst_n, .cfg_we, .cfg_wdata, .cfg_rdata,
                     .ir_rx_pin, .tx_pin, .rx_pulse);

  always #5 clk = ~clk;

  // behavioural reference
  bit dly[$] = '{0, 0, 0};
  logic [7:0] mctl = 0;
  bit exp_q = 0, alive = 0;
  int run = 0, need = 0;

  always @(posedge clk) begin
    bit act, hi, rise, src, nx;
    if (!rst_n) begin
      dly = '{0, 0, 0}; mctl = 0; exp_q = 0; alive = 0; run = 0;
    end else begin
      act = mctl[0] && mctl[1];
      hi = dly[1]; rise = dly[1] && !dly[2];
      nx = 0;
      if (!act) alive = 0;
      if (rise) begin
        run = 1; alive = 0;
        if (act) begin
          if (mctl[7:4] == 0) nx = 1;
          else begin need = int'(mctl[7:4]) * 4 + 3; alive = 1; end
        end
      end else if (hi) begin
        run++;
        if (alive && run == need) begin nx = 1; alive = 0; end
      end else alive = 0;
      exp_q = nx;
      src = mctl[2] ? !tx_pin : ir_rx_pin;
      if (cfg_we) mctl = cfg_wdata & 8'hF7;
      dly.push_front(src);
      void'(dly.pop_back());
    end
  end

  always @(negedge clk) if (rst_n) begin
    checks++;
    if (rx_pulse !== exp_q) begin
      fails++;
      $display("FAIL R5 per-cycle strobe at %0t: actual=%b expected=%b", $time, rx_pulse, exp_q);
    end
    if (rx_pulse === 1'b1) strobes++;
  end

  task automatic chk(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic wcfg(logic [7:0] v);
    @(negedge clk); cfg_we = 1; cfg_wdata = v;
    @(negedge clk); cfg_we = 0;
  endtask

  task automatic pin_pulse(int w);
    @(negedge clk); ir_rx_pin = 1;
    repeat (w) @(negedge clk);
    ir_rx_pin = 0;
    repeat (12) @(negedge clk);
  endtask

  task automatic tx_pulse(int w);
    @(negedge clk); tx_pin = 0;
    repeat (w) @(negedge clk);
    tx_pin = 1;
    repeat (12) @(negedge clk);
  endtask

  initial begin
    fork
      begin
        repeat (3) @(negedge clk);
        rst_n = 1;
        chk("R1 reset read", cfg_rdata, 0);
        chk("R1 reset strobe", rx_pulse, 0);
        wcfg(8'hFF);
        chk("R2 reserved bit", cfg_rdata, 8'hF7);
        wcfg(8'h03);
        // R3 latency: strobe in cycle after third sampling edge
        @(negedge clk); ir_rx_pin = 1;
        repeat (2) @(negedge clk);
        chk("R3 not yet", rx_pulse, 0);
        @(negedge clk);
        chk("R3 latency", rx_pulse, 1);
        repeat (4) @(negedge clk); ir_rx_pin = 0;
        repeat (8) @(negedge clk);
        strobes = 0; pin_pulse(1);
        chk("R4 one-clock pulse", strobes, 1);
        strobes = 0; pin_pulse(30);
        chk("R6 long pulse edge mode", strobes, 1);
        wcfg(8'h13);
        strobes = 0; pin_pulse(6);
        chk("R5 field1 width6 rejected", strobes, 0);
        strobes = 0; pin_pulse(7);
        chk("R5 field1 width7 accepted", strobes, 1);
        strobes = 0; pin_pulse(40);
        chk("R6 field1 long pulse once", strobes, 1);
        wcfg(8'hF3);
        strobes = 0; pin_pulse(62);
        chk("R5 field15 width62 rejected", strobes, 0);
        strobes = 0; pin_pulse(63);
        chk("R5 field15 width63 accepted", strobes, 1);
        // R7: mid-pulse change from field1 to field15
        wcfg(8'h13);
        strobes = 0;
        @(negedge clk); ir_rx_pin = 1;
        repeat (2) @(negedge clk);
        cfg_we = 1; cfg_wdata = 8'hF3;
        @(negedge clk); cfg_we = 0;
        repeat (7) @(negedge clk); ir_rx_pin = 0;
        repeat (12) @(negedge clk);
        chk("R7 field latched at edge", strobes, 1);
        wcfg(8'h17);
        strobes = 0; pin_pulse(20);
        chk("R8 pin ignored in loopback", strobes, 0);
        strobes = 0; tx_pulse(8);
        chk("R8 inverted tx accepted", strobes, 1);
        strobes = 0; tx_pulse(5);
        chk("R8 short tx rejected", strobes, 0);
        wcfg(8'h01);
        strobes = 0; pin_pulse(20);
        chk("R9 receive disabled", strobes, 0);
        wcfg(8'h02);
        strobes = 0; pin_pulse(20);
        chk("R10 block disabled", strobes, 0);
        wcfg(8'h00);
        strobes = 0; pin_pulse(3);
        chk("R10 all off", strobes, 0);
      end
      begin
        repeat (20000) @(negedge clk);
        checks++; fails++;
        $display("FAIL watchdog expired actual=running expected=done");
      end
    join_any
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule